// File: doc/BRIEF.md
# Two-Channel PWM Timer with Fast and Phase-Correct Modes

This block is an 8-bit timer that drives two pulse-width-modulated outputs, A and B, from one shared counter. Each output has its own 8-bit compare value. The counter either counts up and wraps, which gives a 256-tick period, or counts up to 255 and back down to 0, which gives a 510-tick period with a centred pulse. A prescaler divides the system clock by 1, 8, 64, 256 or 1024 to make the counter tick, or it stops the counter.

Software sets the block up through a synchronous write port with an address, a data byte and a write enable. New compare values go into a buffer first. They reach the comparator only at the end of a period, so a period is never cut short. Each channel can be turned off (output held low), non-inverting or inverting.

Register map (by write address): 0 = control, with bits [2:0] the clock select and bits [5:3] the counting mode; 1 = output modes, with bits [1:0] for channel A and bits [3:2] for channel B; 2 = compare buffer A; 3 = compare buffer B. Bits not listed are ignored.

Top module: `dual_pwm_timer`

## Requirements
- R1: After the asynchronous reset every register is 0. The counter is stopped and both outputs are low.
- R2: With counting mode 011 (fast), the counter steps 0,1,…,255,0 on each tick. A non-inverting channel with compare value K (1..254) is high for K ticks out of every 256.
- R3: With counting mode 001 (phase-correct), the counter steps 0 up to 255 and then down to 0, which is a 510-tick period. A non-inverting channel is high while the count is below K, so it is high for 2K-1 ticks out of every 510. It therefore clears on the match while counting up and sets again while counting down.
- R4: Output-mode codes: 00 and 01 drive the output low, 10 is non-inverting and 11 is inverting. An inverting channel is the exact complement of the non-inverting waveform.
- R5: Clock-select codes give one counter tick every N system clocks: 001 gives N=1, 010 gives N=8, 011 gives N=64, 100 gives N=256 and 101 gives N=1024. Codes 000, 110 and 111 stop the counter, and both outputs then hold their levels.
- R6: Counting mode 011 selects fast counting. Every other code of the 3-bit mode field selects phase-correct counting.
- R7: A write to a compare address only fills that channel's buffer. The buffer moves into the active compare value when the counter reaches 0 in fast mode, or 255 in phase-correct mode.
- R8: For a non-inverting channel, an active compare value of 0 gives a constant low output and 255 gives a constant high output, in both modes.
- R9: The two channels share the counter and nothing else. Each channel's compare value and output mode affect only its own output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Write strobe, sampled on the rising edge |
| wr_addr_i | input | 2 | Register address |
| wr_data_i | input | 8 | Write data |
| pwm_a_o | output | 1 | Channel A waveform |
| pwm_b_o | output | 1 | Channel B waveform |

## Verification
A write takes effect at the clock edge that samples it. The prescaler restarts from zero when it leaves the stopped state, so with a divide ratio N the first tick is due N clocks later. Both outputs come straight from registers and change at the edge of a tick, so the bench drives inputs and samples outputs on the falling edge. A cycle-exact bench model, built from the requirements, predicts every output, and the outputs are compared with it every cycle. Duty-cycle checks count high cycles over whole periods, and they start only after a settling wait longer than one period, so any buffered compare value has already been loaded.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;
  typedef enum logic [1:0] {
    OM_OFF    = 2'b00,
    OM_RSV    = 2'b01,
    OM_NONINV = 2'b10,
    OM_INV    = 2'b11
  } out_mode_e;

  localparam logic [1:0] ADDR_CTRL  = 2'd0;
  localparam logic [1:0] ADDR_OMODE = 2'd1;
  localparam logic [1:0] ADDR_CMP_A = 2'd2;
  localparam logic [1:0] ADDR_CMP_B = 2'd3;

  localparam logic [2:0] WAVE_FAST  = 3'b011;
endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
  parameter int PRESC_W = 10
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] clk_sel_i,
  output logic       tick_o
);
  logic [PRESC_W-1:0] div_q;
  logic [PRESC_W-1:0] mask;
  logic               run;

  always_comb begin
    run  = 1'b1;
    mask = '0;
    unique case (clk_sel_i)
      3'd1:    mask = '0;
      3'd2:    mask = PRESC_W'(7);
      3'd3:    mask = PRESC_W'(63);
      3'd4:    mask = PRESC_W'(255);
      3'd5:    mask = PRESC_W'(1023);
      default: run  = 1'b0;
    endcase
  end

  assign tick_o = run && ((div_q & mask) == mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   div_q <= '0;
    else if (!run) div_q <= '0;
    else           div_q <= div_q + PRESC_W'(1);
  end
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             fast_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cnt_nxt_o,
  output logic             load_o
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic             up_q, up_nxt;

  always_comb begin
    up_nxt    = up_q;
    cnt_nxt_o = cnt_q + CNT_W'(1);
    if (fast_i) begin
      up_nxt = 1'b1;
    end else if (up_q) begin
      if (cnt_q == TOP) begin
        cnt_nxt_o = TOP - CNT_W'(1);
        up_nxt    = 1'b0;
      end
    end else if (cnt_q == '0) begin
      up_nxt = 1'b1;
    end else begin
      cnt_nxt_o = cnt_q - CNT_W'(1);
    end
  end

  // buffered compare loads at bottom (fast) or top (dual slope)
  assign load_o = tick_i && (fast_i ? (cnt_nxt_o == '0) : (cnt_nxt_o == TOP));
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      up_q  <= 1'b1;
    end else if (tick_i) begin
      cnt_q <= cnt_nxt_o;
      up_q  <= up_nxt;
    end
  end
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
  import pwm_timer_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] cnt_nxt_i,
  input  logic [CNT_W-1:0] cmp_buf_i,
  input  out_mode_e        out_mode_i,
  output logic [CNT_W-1:0] act_o,
  output logic             pwm_o
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  logic [CNT_W-1:0] act_q, act_nxt;
  logic             level_q;

  assign act_nxt = load_i ? cmp_buf_i : act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q   <= '0;
      level_q <= 1'b0;
    end else if (tick_i) begin
      act_q   <= act_nxt;
      level_q <= (cnt_nxt_i < act_nxt) || (act_nxt == TOP);
    end
  end

  always_comb begin
    unique case (out_mode_i)
      OM_NONINV: pwm_o = level_q;
      OM_INV:    pwm_o = ~level_q;
      default:   pwm_o = 1'b0;
    endcase
  end

  assign act_o = act_q;
endmodule

// File: rtl/dual_pwm_timer.sv
module dual_pwm_timer
  import pwm_timer_pkg::*;
#(
  parameter int CNT_W   = 8,
  parameter int PRESC_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_addr_i,
  input  logic [CNT_W-1:0] wr_data_i,
  output logic             pwm_a_o,
  output logic             pwm_b_o
);
  localparam int N_CH = 2;

  logic [2:0]       clk_sel_q;
  logic [2:0]       wave_q;
  out_mode_e        omode_q [N_CH];
  logic [CNT_W-1:0] cmp_buf_q [N_CH];
  logic [CNT_W-1:0] act [N_CH];
  logic [N_CH-1:0]  pwm;
  logic             tick, fast, load;
  logic [CNT_W-1:0] cnt, cnt_nxt;
  logic             unused_bits;

  assign fast        = (wave_q == WAVE_FAST);
  assign unused_bits = ^{wr_data_i[CNT_W-1:6], wr_data_i[5:4]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clk_sel_q <= '0;
      wave_q    <= '0;
      for (int i = 0; i < N_CH; i++) begin
        omode_q[i]   <= OM_OFF;
        cmp_buf_q[i] <= '0;
      end
    end else if (wr_en_i) begin
      unique case (wr_addr_i)
        ADDR_CTRL: begin
          clk_sel_q <= wr_data_i[2:0];
          wave_q    <= wr_data_i[5:3];
        end
        ADDR_OMODE: begin
          omode_q[0] <= out_mode_e'(wr_data_i[1:0]);
          omode_q[1] <= out_mode_e'(wr_data_i[3:2]);
        end
        ADDR_CMP_A: cmp_buf_q[0] <= wr_data_i;
        default:    cmp_buf_q[1] <= wr_data_i;
      endcase
    end
  end

  pwm_prescaler #(.PRESC_W(PRESC_W)) u_presc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clk_sel_i (clk_sel_q),
    .tick_o    (tick)
  );

  pwm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick),
    .fast_i    (fast),
    .cnt_o     (cnt),
    .cnt_nxt_o (cnt_nxt),
    .load_o    (load)
  );

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    pwm_channel #(.CNT_W(CNT_W)) u_ch (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .tick_i     (tick),
      .load_i     (load),
      .cnt_nxt_i  (cnt_nxt),
      .cmp_buf_i  (cmp_buf_q[g]),
      .out_mode_i (omode_q[g]),
      .act_o      (act[g]),
      .pwm_o      (pwm[g])
    );
  end

  assign pwm_a_o = pwm[0];
  assign pwm_b_o = pwm[1];
endmodule

// File: rtl/pwm_timer_chk.sv
module pwm_timer_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_i,
  input logic             fast_i,
  input logic [2:0]       clk_sel_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic [CNT_W-1:0] act_a_i,
  input logic [CNT_W-1:0] act_b_i,
  input logic [1:0]       om_a_i,
  input logic [1:0]       om_b_i,
  input logic             pwm_a_i,
  input logic             pwm_b_i
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  assert_fast_wrap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && fast_i && cnt_i == TOP) |=> (cnt_i == '0));

  assert_phase_turn_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !fast_i && cnt_i == TOP) |=> (cnt_i == TOP - CNT_W'(1)));

  assert_phase_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !fast_i) |=> (cnt_i == CNT_W'($past(cnt_i) + 1'b1) ||
                             cnt_i == CNT_W'($past(cnt_i) - 1'b1)));

  assert_stop_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_sel_i == 3'd0 || clk_sel_i > 3'd5) |=> $stable(cnt_i));

  assert_load_on_tick_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> ($stable(act_a_i) && $stable(act_b_i)));

  assert_full_high_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (om_a_i == 2'b10 && act_a_i == TOP) |-> pwm_a_i);

  assert_zero_low_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (om_b_i == 2'b10 && act_b_i == '0) |-> !pwm_b_i);

  assert_off_low_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (om_a_i[1] == 1'b0) |-> !pwm_a_i);
endmodule

bind dual_pwm_timer pwm_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tick_i    (tick),
  .fast_i    (fast),
  .clk_sel_i (clk_sel_q),
  .cnt_i     (cnt),
  .act_a_i   (act[0]),
  .act_b_i   (act[1]),
  .om_a_i    (omode_q[0]),
  .om_b_i    (omode_q[1]),
  .pwm_a_i   (pwm_a_o),
  .pwm_b_i   (pwm_b_o)
);

// File: tb/tb_dual_pwm_timer.sv
module tb_dual_pwm_timer;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       pwm_a, pwm_b;

  int  n_chk = 0;
  int  n_fail = 0;
  bit  done = 1'b0;

  always #10 clk = ~clk;

  dual_pwm_timer dut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .pwm_a_o(pwm_a), .pwm_b_o(pwm_b)
  );

  // reference model built from the requirements
  logic [2:0] m_cs, m_wm;
  logic [1:0] m_om [2];
  logic [7:0] m_buf [2];
  logic [7:0] m_act [2];
  logic       m_lvl [2];
  logic [9:0] m_div;
  logic [7:0] m_cnt;
  logic       m_up;

  always @(posedge clk or negedge rst_ni) begin
    logic [9:0] mask;
    logic       run, tk, ld;
    logic [7:0] nc;
    if (!rst_ni) begin
      m_cs = 0; m_wm = 0; m_div = 0; m_cnt = 0; m_up = 1;
      for (int i = 0; i < 2; i++) begin
        m_om[i] = 0; m_buf[i] = 0; m_act[i] = 0; m_lvl[i] = 0;
      end
    end else begin
      run  = (m_cs >= 3'd1 && m_cs <= 3'd5);
      mask = (m_cs == 3'd1) ? 10'd0 : (m_cs == 3'd2) ? 10'd7 : (m_cs == 3'd3) ? 10'd63 :
             (m_cs == 3'd4) ? 10'd255 : 10'd1023;
      tk    = run && ((m_div & mask) == mask);
      m_div = run ? m_div + 10'd1 : 10'd0;
      if (tk) begin
        if (m_wm == 3'b011) begin
          nc = m_cnt + 8'd1; m_up = 1; ld = (nc == 8'd0);
        end else begin
          if (m_up) begin
            if (m_cnt == 8'd255) begin nc = 8'd254; m_up = 0; end
            else nc = m_cnt + 8'd1;
          end else begin
            if (m_cnt == 8'd0) begin nc = 8'd1; m_up = 1; end
            else nc = m_cnt - 8'd1;
          end
          ld = (nc == 8'd255);
        end
        m_cnt = nc;
        for (int i = 0; i < 2; i++) begin
          if (ld) m_act[i] = m_buf[i];
          m_lvl[i] = (m_cnt < m_act[i]) || (m_act[i] == 8'd255);
        end
      end
      if (wr_en) begin
        case (wr_addr)
          2'd0: begin m_cs = wr_data[2:0]; m_wm = wr_data[5:3]; end
          2'd1: begin m_om[0] = wr_data[1:0]; m_om[1] = wr_data[3:2]; end
          2'd2: m_buf[0] = wr_data;
          default: m_buf[1] = wr_data;
        endcase
      end
    end
  end

  function automatic logic exp_out(input logic [1:0] om, input logic lvl);
    return (om == 2'b10) ? lvl : (om == 2'b11) ? ~lvl : 1'b0;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_ni && !done) begin
      chk(pwm_a == exp_out(m_om[0], m_lvl[0]), (m_wm == 3'b011) ? "R2 model A" : "R3 model A",
          pwm_a, exp_out(m_om[0], m_lvl[0]));
      chk(pwm_b == exp_out(m_om[1], m_lvl[1]), "R9 model B", pwm_b, exp_out(m_om[1], m_lvl[1]));
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic count_high(input int n, input bit ch_b, output int h);
    h = 0;
    repeat (n) begin
      @(negedge clk);
      h += ch_b ? int'(pwm_b) : int'(pwm_a);
    end
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    int  h;
    bit  prev, held;
    void'($urandom(32'd1234));
    wait_cyc(3);
    rst_ni = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk(!pwm_a && !pwm_b, "R1 reset outputs", {pwm_a, pwm_b}, 0);
    end

    // fast mode, N=1, A non-inverting K=100, B non-inverting K=30
    wr(2'd1, 8'b0000_1010);
    wr(2'd2, 8'd100);
    wr(2'd3, 8'd30);
    wr(2'd0, {2'b00, 3'b011, 3'b001});
    wait_cyc(600);
    count_high(256, 0, h); chk(h == 100, "R2 fast duty A", h, 100);

    // B inverting, A untouched
    wr(2'd1, 8'b0000_1110);
    wait_cyc(300);
    count_high(256, 1, h); chk(h == 226, "R9 B inverting K=30", h, 226);
    count_high(256, 0, h); chk(h == 100, "R9 A unaffected", h, 100);

    // A inverting and reserved code
    wr(2'd1, 8'b0000_1011);
    wait_cyc(10);
    count_high(256, 0, h); chk(h == 156, "R4 inverting A", h, 156);
    wr(2'd1, 8'b0000_1001);
    count_high(256, 0, h); chk(h == 0, "R4 code 01 low", h, 0);

    // compare extremes
    wr(2'd1, 8'b0000_1010);
    wr(2'd2, 8'd0);
    wait_cyc(600);
    count_high(256, 0, h); chk(h == 0, "R8 K=0 low", h, 0);
    wr(2'd2, 8'd255);
    wait_cyc(600);
    count_high(256, 0, h); chk(h == 256, "R8 K=255 high", h, 256);

    // phase-correct
    wr(2'd2, 8'd100);
    wr(2'd0, {2'b00, 3'b001, 3'b001});
    wait_cyc(1100);
    count_high(510, 0, h); chk(h == 199, "R3 phase duty A", h, 199);
    wr(2'd2, 8'd255);
    wait_cyc(1100);
    count_high(510, 0, h); chk(h == 510, "R8 phase K=255", h, 510);
    wr(2'd2, 8'd100);
    wr(2'd0, {2'b00, 3'b101, 3'b001});
    wait_cyc(1100);
    count_high(510, 0, h); chk(h == 199, "R6 mode 101 dual slope", h, 199);
    wr(2'd0, {2'b00, 3'b011, 3'b001});
    wait_cyc(600);
    count_high(256, 0, h); chk(h == 100, "R6 mode 011 fast", h, 100);

    // prescale N=8, fast, K=64
    wr(2'd2, 8'd64);
    wr(2'd0, {2'b00, 3'b011, 3'b010});
    wait_cyc(4200);
    count_high(2048, 0, h); chk(h == 512, "R5 N=8 duty", h, 512);

    // stop codes hold outputs
    for (int s = 0; s < 3; s++) begin
      wr(2'd0, {2'b00, 3'b011, (s == 0) ? 3'b000 : (s == 1) ? 3'b110 : 3'b111});
      prev = pwm_a;
      held = 1'b1;
      repeat (200) begin
        @(negedge clk);
        if (pwm_a != prev) held = 1'b0;
      end
      chk(held, "R5 stop holds output", held, 1);
      wr(2'd0, {2'b00, 3'b011, 3'b001});
      wait_cyc(37 + s * 61);
    end

    // buffered compare: new value not used mid-period
    wr(2'd2, 8'd200);
    wait_cyc(600);
    prev = pwm_a;
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      if (prev && !pwm_a) break;
      prev = pwm_a;
    end
    wr_en = 1'b1; wr_addr = 2'd2; wr_data = 8'd250;
    @(negedge clk);
    wr_en = 1'b0;
    for (int i = 0; i < 40; i++) begin
      chk(!pwm_a, "R7 buffer not applied mid-period", pwm_a, 0);
      @(negedge clk);
    end
    wait_cyc(600);
    count_high(256, 0, h); chk(h == 250, "R7 buffer applied", h, 250);

    // constrained random
    for (int it = 0; it < 40; it++) begin
      logic [1:0] a;
      logic [7:0] d;
      a = 2'($urandom_range(0, 3));
      d = 8'($urandom);
      if (a == 2'd0)
        d = {2'b00, ($urandom_range(0, 2) == 0) ? 3'b001 : ($urandom_range(0, 1) == 0) ? 3'b011
             : 3'($urandom), 3'($urandom_range(0, 3))};
      if (it % 8 == 0) d = (a == 2'd0) ? 8'h19 : 8'($urandom_range(0, 1) * 255);
      wr(a, d);
      wait_cyc($urandom_range(20, 800));
    end

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_fail++;
      $display("FAIL R1 watchdog expired actual=%0d expected=%0d", 0, 1);
      summary();
      $finish;
    end
  end
endmodule